// File: doc/BRIEF.md
# SMBus Indexed Block Register Target

This block is an SMBus target that holds a small control register file of 32 bytes. A bus controller reaches the registers through indexed block transfers. Every transfer names a start offset, and a write also gives an explicit byte count. The block watches SCL and SDA and only ever pulls SDA low through a drive-low output. It presents the whole register image in parallel to the logic around it.

A write transfer carries the write address, an offset, a count and then the data bytes. Each data byte goes to the next location up from the offset, and the location pointer wraps from 31 back to 0. A read transfer carries the write address and the offset, then a repeated start with the read address. The target first returns a count byte, held in register byte 8, and then the data bytes from the offset upward. It keeps sending until the controller does not acknowledge a byte.

Register byte 3 carries three latched frequency-select status bits in its top bits. Byte 7 is a fixed identity byte. Bytes 9 to 16 are placeholders. Both SCL and SDA are synchronised into the system clock, and start and stop conditions are found from SDA edges while SCL is high.

Top module: `smbx_target`

## Requirements
- R1: After reset, bytes 0 to 2 read FFh, byte 8 reads 08h, byte 7 reads VENDOR_REV (default 15h), byte 3 reads {fs_i, 5'b00000}, and every other byte reads 00h.
- R2: The target acknowledges address byte D2h (write) and D3h (read). Any other address byte is not acknowledged, and the target then leaves SDA released for the rest of that transfer.
- R3: In a write, the offset byte and a nonzero count byte are acknowledged. Each data byte, up to the count, is acknowledged and stored at offset, offset+1, and so on. A count of 01h writes exactly one byte. Only one register byte changes at a time.
- R4: A count byte of 00h is not acknowledged, and no register changes.
- R5: Data bytes beyond the count are not acknowledged and are not stored.
- R6: The location pointer wraps from 31 to 0 during writes and during reads.
- R7: After a repeated start and D3h, the target sends register byte 8 as the count byte. It then sends data bytes from the offset upward, MSB first.
- R8: A data byte the controller does not acknowledge ends the read, and the target releases SDA. A read may end before the count is reached, and the next transfer still works.
- R9: Bits [7:5] of byte 3 always show fs_i, and only bits [4:0] of byte 3 are writable. Byte 7 is always VENDOR_REV, and writes to it are ignored.
- R10: Bytes 9 to 16 always read 00h. Writes to them are acknowledged but have no effect.
- R11: The target changes SDA only while SCL is low, and register bytes change only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; it must be much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| fs_i | input | FSW (3) | Latched frequency-select status bits, shown in byte 3 |
| sda_low_o | output | 1 | When 1, the pad pulls SDA low |
| regs_o | output | NBYTES*8 (256) | Register image; byte i is at bits [8i+7:8i] |

## Verification
A corrupted location pointer shows up on regs_o in the cycle after the next stored data byte, because that byte lands in the wrong place. In a read it shows up at the very next data bit. A wrong protocol phase shows up within one bus bit, as an acknowledge driven or withheld at the wrong time on SDA. A bad write mask or reset value shows up directly on regs_o, which the bench compares every clock while the bus is idle. Acknowledges and returned bytes are compared at every bus bit.

// File: rtl/smbx_pkg.sv
// Shared types for the SMBus indexed register target.
// Assumes: nothing beyond the standard language.
package smbx_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,    // not addressed; SDA released
        PH_RX,      // shifting in a byte from the controller
        PH_ACK_TX,  // holding SDA low for our acknowledge
        PH_TX,      // shifting out a byte to the controller
        PH_ACK_RX   // sampling the controller's acknowledge
    } phase_e;

    typedef enum logic [1:0] {
        RB_ADDR,    // device address byte
        RB_OFFSET,  // start offset
        RB_COUNT,   // write byte count
        RB_DATA     // write data
    } rxrole_e;
endpackage

// File: rtl/smbx_sync_edge.sv
// Brings SCL and SDA into the clock domain and flags bus events.
// Assumes: STAGES >= 2; clk is several times faster than SCL.
module smbx_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s_o,
    output logic sda_s_o,
    output logic start_o,
    output logic stop_o,
    output logic scl_rise_o,
    output logic scl_fall_o
);
    logic [STAGES-1:0] scl_pipe, sda_pipe;
    logic              scl_d, sda_d;

    // Synchronizer chains plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_d    <= scl_pipe[STAGES-1];
            sda_d    <= sda_pipe[STAGES-1];
        end
    end

    // Bus events from the synchronised lines.
    always_comb begin
        scl_s_o    = scl_pipe[STAGES-1];
        sda_s_o    = sda_pipe[STAGES-1];
        start_o    = scl_s_o && scl_d && sda_d && !sda_s_o;
        stop_o     = scl_s_o && scl_d && !sda_d && sda_s_o;
        scl_rise_o = scl_s_o && !scl_d;
        scl_fall_o = !scl_s_o && scl_d;
    end
endmodule

// File: rtl/smbx_regfile.sv
// Register bytes with power-on values, write masks and read-only mapping.
// Assumes: one write port; byte positions given by parameters lie inside NBYTES.
module smbx_regfile #(
    parameter int         NBYTES     = 32,
    parameter int         AW         = 5,
    parameter int         FSW        = 3,
    parameter int         FS_BYTE    = 3,
    parameter int         FS_LSB     = 5,
    parameter int         VEND_BYTE  = 7,
    parameter logic [7:0] VENDOR_REV = 8'h15,
    parameter int         COUNT_BYTE = 8,
    parameter logic [7:0] COUNT_RST  = 8'h08,
    parameter int         DUMMY_LO   = 9,
    parameter int         DUMMY_HI   = 16,
    parameter int         ONES_BYTES = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we_i,
    input  logic [AW-1:0]       waddr_i,
    input  logic [7:0]          wdata_i,
    input  logic [FSW-1:0]      fs_i,
    input  logic [AW-1:0]       raddr_i,
    output logic [7:0]          rdata_o,
    output logic [NBYTES*8-1:0] regs_o
);
    logic [7:0] view [NBYTES];

    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        if (i == VEND_BYTE) begin : g_fixed
            assign view[i] = VENDOR_REV;
        end else if (i >= DUMMY_LO && i <= DUMMY_HI) begin : g_dummy
            assign view[i] = 8'h00;
        end else begin : g_store
            localparam logic [7:0] RST  = (i < ONES_BYTES) ? 8'hFF :
                                          (i == COUNT_BYTE) ? COUNT_RST : 8'h00;
            localparam logic [7:0] MASK = (i == FS_BYTE) ?
                                          ~(8'((1 << FSW) - 1) << FS_LSB) : 8'hFF;
            logic [7:0] q;
            // Holds the writable bits of this byte.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= RST & MASK;
                else if (we_i && (waddr_i == AW'(i)))
                    q <= wdata_i & MASK;
            end
            if (i == FS_BYTE) begin : g_fs
                assign view[i] = q | (8'(fs_i) << FS_LSB);
            end else begin : g_plain
                assign view[i] = q;
            end
        end
        assign regs_o[i*8 +: 8] = view[i];
    end

    assign rdata_o = view[raddr_i];
endmodule

// File: rtl/smbx_proto.sv
// Bus protocol engine: address, offset and count decode, acknowledges,
// data shifting in both directions.
// Assumes: events come from smbx_sync_edge; SCL low lasts well over 3 clocks.
module smbx_proto
    import smbx_pkg::*;
#(
    parameter int         AW       = 5,
    parameter logic [6:0] DEV_ADDR = 7'h69
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          stop_i,
    input  logic          scl_rise_i,
    input  logic          scl_fall_i,
    input  logic          sda_s_i,
    input  logic [7:0]    rdata_i,
    input  logic [7:0]    count_i,
    output logic          we_o,
    output logic [AW-1:0] waddr_o,
    output logic [7:0]    wdata_o,
    output logic [AW-1:0] raddr_o,
    output logic          sda_low_o
);
    phase_e        phase;
    rxrole_e       role;
    logic [3:0]    bitcnt;
    logic [7:0]    shreg;
    logic [AW-1:0] ptr;
    logic [7:0]    remain;
    logic          tx_next;
    logic          more;

    assign raddr_o = ptr;

    // Protocol state machine; bits are taken on SCL rise and SDA moves on SCL fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            role      <= RB_ADDR;
            bitcnt    <= '0;
            shreg     <= '0;
            ptr       <= '0;
            remain    <= '0;
            tx_next   <= 1'b0;
            more      <= 1'b0;
            sda_low_o <= 1'b0;
            we_o      <= 1'b0;
            waddr_o   <= '0;
            wdata_o   <= '0;
        end else begin
            we_o <= 1'b0;
            if (start_i) begin
                phase     <= PH_RX;
                role      <= RB_ADDR;
                bitcnt    <= '0;
                sda_low_o <= 1'b0;
            end else if (stop_i) begin
                phase     <= PH_IDLE;
                sda_low_o <= 1'b0;
            end else begin
                case (phase)
                    PH_RX: begin
                        if (scl_rise_i && bitcnt != 4'd8) begin
                            shreg  <= {shreg[6:0], sda_s_i};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall_i && bitcnt == 4'd8) begin
                            bitcnt    <= '0;
                            phase     <= PH_ACK_TX;
                            sda_low_o <= 1'b1;
                            case (role)
                                RB_ADDR: begin
                                    if (shreg == {DEV_ADDR, 1'b0}) begin
                                        role    <= RB_OFFSET;
                                        tx_next <= 1'b0;
                                    end else if (shreg == {DEV_ADDR, 1'b1}) begin
                                        tx_next <= 1'b1;
                                    end else begin
                                        phase     <= PH_IDLE;
                                        sda_low_o <= 1'b0;
                                    end
                                end
                                RB_OFFSET: begin
                                    ptr  <= shreg[AW-1:0];
                                    role <= RB_COUNT;
                                end
                                RB_COUNT: begin
                                    if (shreg == 8'h00) begin
                                        phase     <= PH_IDLE;
                                        sda_low_o <= 1'b0;
                                    end else begin
                                        remain <= shreg;
                                        role   <= RB_DATA;
                                    end
                                end
                                RB_DATA: begin
                                    if (remain != 8'h00) begin
                                        we_o    <= 1'b1;
                                        waddr_o <= ptr;
                                        wdata_o <= shreg;
                                        ptr     <= ptr + AW'(1);
                                        remain  <= remain - 8'd1;
                                    end else begin
                                        phase     <= PH_IDLE;
                                        sda_low_o <= 1'b0;
                                    end
                                end
                                default: ;
                            endcase
                        end
                    end
                    PH_ACK_TX: begin
                        if (scl_fall_i) begin
                            bitcnt <= '0;
                            if (tx_next) begin
                                shreg     <= count_i;
                                sda_low_o <= !count_i[7];
                                phase     <= PH_TX;
                            end else begin
                                sda_low_o <= 1'b0;
                                phase     <= PH_RX;
                            end
                        end
                    end
                    PH_TX: begin
                        if (scl_rise_i) begin
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall_i) begin
                            if (bitcnt == 4'd8) begin
                                sda_low_o <= 1'b0;
                                phase     <= PH_ACK_RX;
                            end else begin
                                shreg     <= {shreg[6:0], 1'b0};
                                sda_low_o <= !shreg[6];
                            end
                        end
                    end
                    PH_ACK_RX: begin
                        if (scl_rise_i) begin
                            more <= !sda_s_i;
                        end else if (scl_fall_i) begin
                            if (more) begin
                                shreg     <= rdata_i;
                                sda_low_o <= !rdata_i[7];
                                ptr       <= ptr + AW'(1);
                                bitcnt    <= '0;
                                phase     <= PH_TX;
                            end else begin
                                phase <= PH_IDLE;
                            end
                        end
                    end
                    default: phase <= PH_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/smbx_target.sv
// Top of the SMBus indexed block register target.
// Assumes: SDA pad is open-drain and driven low when sda_low_o is 1;
// no clock stretching; NBYTES > DUMMY_HI.
module smbx_target #(
    parameter int         NBYTES      = 32,
    parameter int         AW          = $clog2(NBYTES),
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter logic [7:0] VENDOR_REV  = 8'h15,
    parameter int         FSW         = 3,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_i,
    input  logic                sda_i,
    input  logic [FSW-1:0]      fs_i,
    output logic                sda_low_o,
    output logic [NBYTES*8-1:0] regs_o
);
    localparam int FS_BYTE    = 3;
    localparam int FS_LSB     = 8 - FSW;
    localparam int VEND_BYTE  = 7;
    localparam int COUNT_BYTE = 8;
    localparam int DUMMY_LO   = 9;
    localparam int DUMMY_HI   = 16;

    logic          scl_sync, sda_sync, ev_start, ev_stop, ev_rise, ev_fall;
    logic          we;
    logic [AW-1:0] waddr, raddr;
    logic [7:0]    wdata, rdata;

    smbx_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s_o(scl_sync), .sda_s_o(sda_sync), .start_o(ev_start),
        .stop_o(ev_stop), .scl_rise_o(ev_rise), .scl_fall_o(ev_fall)
    );

    smbx_proto #(.AW(AW), .DEV_ADDR(DEV_ADDR)) u_proto (
        .clk(clk), .rst_n(rst_n), .start_i(ev_start), .stop_i(ev_stop),
        .scl_rise_i(ev_rise), .scl_fall_i(ev_fall), .sda_s_i(sda_sync),
        .rdata_i(rdata), .count_i(regs_o[COUNT_BYTE*8 +: 8]),
        .we_o(we), .waddr_o(waddr), .wdata_o(wdata), .raddr_o(raddr),
        .sda_low_o(sda_low_o)
    );

    smbx_regfile #(
        .NBYTES(NBYTES), .AW(AW), .FSW(FSW), .FS_BYTE(FS_BYTE), .FS_LSB(FS_LSB),
        .VEND_BYTE(VEND_BYTE), .VENDOR_REV(VENDOR_REV), .COUNT_BYTE(COUNT_BYTE),
        .COUNT_RST(8'h08), .DUMMY_LO(DUMMY_LO), .DUMMY_HI(DUMMY_HI), .ONES_BYTES(3)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
        .fs_i(fs_i), .raddr_i(raddr), .rdata_o(rdata), .regs_o(regs_o)
    );
endmodule

// File: rtl/smbx_target_chk.sv
// Protocol and register-image properties for smbx_target, bound to it below.
// Assumes: SCL low phase lasts longer than three clocks.
module smbx_target_chk #(
    parameter int NBYTES = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                scl_s,
    input logic                sda_low,
    input logic [NBYTES*8-1:0] regs
);
    localparam int FS_BYTE  = 3;
    localparam int DUMMY_LO = 9;
    localparam int DUMMY_HI = 16;

    logic [NBYTES*8-1:0] prev;
    logic                prev_ok;
    logic [NBYTES-1:0]   chg;

    // Keeps last cycle's image to see which bytes moved.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev    <= '0;
            prev_ok <= 1'b0;
        end else begin
            prev    <= regs;
            prev_ok <= 1'b1;
        end
    end

    for (genvar i = 0; i < NBYTES; i++) begin : g_chg
        if (i == FS_BYTE) begin : g_skip
            assign chg[i] = 1'b0;
        end else begin : g_cmp
            assign chg[i] = (regs[i*8 +: 8] != prev[i*8 +: 8]);
        end
    end

    assert_sda_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_low) |-> !$past(scl_s));

    assert_regs_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_ok && (|chg)) |-> !$past(scl_s));

    assert_one_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
        prev_ok |-> ($countones(chg) <= 1));

    assert_dummy_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        regs[DUMMY_HI*8+7 : DUMMY_LO*8] == '0);
endmodule

bind smbx_target smbx_target_chk #(.NBYTES(NBYTES)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_sync), .sda_low(sda_low_o), .regs(regs_o)
);

// File: tb/smbx_target_tb.sv
// Bench: bit-level bus controller plus a behavioural register model,
// compared with the register image on every idle clock.
module smbx_target_tb;
    localparam int HP = 8;
    localparam logic [7:0] VEND = 8'h15;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         scl_m = 1'b1;
    logic         sda_m = 1'b1;
    logic [2:0]   fs = 3'b010;
    logic         sda_low;
    logic [255:0] regs;
    wire          sda_line = sda_m & ~sda_low;

    always #10 clk = ~clk;

    smbx_target u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .fs_i(fs), .sda_low_o(sda_low), .regs_o(regs)
    );

    int         ncmp = 0;
    int         nbad = 0;
    int         model [32];
    bit         cmp_en = 1'b0;
    bit         finished = 1'b0;
    logic [7:0] wq [$];

    function automatic int expv(int i);
        if (i == 7) return int'(VEND);
        if (i >= 9 && i <= 16) return 0;
        if (i == 3) return (int'(fs) << 5) | (model[3] & 31);
        return model[i];
    endfunction

    function automatic void wmod(int a, int v);
        int k;
        k = a % 32;
        if (k == 7 || (k >= 9 && k <= 16)) return;
        if (k == 3) model[3] = v & 31;
        else model[k] = v & 255;
    endfunction

    task automatic check(string req, int act, int exp);
        ncmp++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Idle-time comparison of the whole register image and SDA release.
    always @(negedge clk) begin
        if (cmp_en && !finished) begin
            int bad;
            bad = -1;
            for (int i = 0; i < 32; i++)
                if (int'(regs[i*8 +: 8]) != expv(i)) bad = i;
            ncmp++;
            if (bad >= 0) begin
                nbad++;
                $display("FAIL R3 image byte %0d: actual %0h expected %0h",
                         bad, regs[bad*8 +: 8], expv(bad));
            end else if (sda_low) begin
                nbad++;
                $display("FAIL R8 idle SDA: actual %0d expected 0", sda_low);
            end
        end
    end

    task automatic hp;
        repeat (HP) @(posedge clk);
        #1;
    endtask

    task automatic bstart;
        cmp_en = 1'b0;
        hp; sda_m = 1'b0; hp; scl_m = 1'b0;
    endtask

    task automatic brstart;
        hp; sda_m = 1'b1; hp; scl_m = 1'b1; hp; sda_m = 1'b0; hp; scl_m = 1'b0;
    endtask

    task automatic bstop;
        hp; sda_m = 1'b0; hp; scl_m = 1'b1; hp; sda_m = 1'b1; hp; hp;
        cmp_en = 1'b1;
        hp;
    endtask

    task automatic wbyte(input logic [7:0] b, output int ack);
        for (int i = 7; i >= 0; i--) begin
            hp; sda_m = b[i]; hp; scl_m = 1'b1; hp; scl_m = 1'b0;
        end
        hp; sda_m = 1'b1; hp; scl_m = 1'b1; hp;
        ack = sda_line ? 0 : 1;
        scl_m = 1'b0;
    endtask

    task automatic rbyte(input bit last, output logic [7:0] b);
        logic first;
        for (int i = 7; i >= 0; i--) begin
            hp; sda_m = 1'b1; hp; scl_m = 1'b1; first = sda_line; hp;
            b[i] = sda_line;
            check("R11 data stable while SCL high", int'(b[i]), int'(first));
            scl_m = 1'b0;
        end
        hp; sda_m = last; hp; scl_m = 1'b1; hp; scl_m = 1'b0; hp; sda_m = 1'b1;
    endtask

    task automatic do_write(int off, int cnt, int nd, string req);
        int a;
        bstart;
        wbyte(8'hD2, a); check({req, " address ack"}, a, 1);
        wbyte(8'(off), a); check({req, " offset ack"}, a, 1);
        wbyte(8'(cnt), a); check({req, " count ack"}, a, (cnt != 0) ? 1 : 0);
        if (a == 1) begin
            for (int k = 0; k < nd; k++) begin
                wbyte(wq[k], a);
                check({req, " data ack"}, a, (k < cnt) ? 1 : 0);
                if (a == 1) wmod(off + k, int'(wq[k]));
                else break;
            end
        end
        bstop;
    endtask

    task automatic do_read(int off, int n, string req);
        int a;
        logic [7:0] b;
        bstart;
        wbyte(8'hD2, a); check({req, " address ack"}, a, 1);
        wbyte(8'(off), a); check({req, " offset ack"}, a, 1);
        brstart;
        wbyte(8'hD3, a); check("R2 read address ack", a, 1);
        rbyte(1'b0, b); check("R7 count byte", int'(b), model[8]);
        for (int k = 0; k < n; k++) begin
            rbyte(k == n - 1, b);
            check({req, " read data"}, int'(b), expv((off + k) % 32));
        end
        hp;
        check("R8 SDA released after not-acknowledge", int'(sda_line), 1);
        bstop;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            nbad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
            $finish;
        end
    end

    initial begin
        int a;
        for (int i = 0; i < 32; i++) model[i] = (i < 3) ? 255 : ((i == 8) ? 8 : 0);
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        hp;
        check("R1 byte0", int'(regs[7:0]), 8'hFF);
        check("R1 byte2", int'(regs[23:16]), 8'hFF);
        check("R1 byte3", int'(regs[31:24]), 8'h40);
        check("R1 byte7", int'(regs[63:56]), 8'h15);
        check("R1 byte8", int'(regs[71:64]), 8'h08);
        check("R1 byte20", int'(regs[167:160]), 8'h00);
        check("R1 SDA released", int'(sda_low), 0);
        cmp_en = 1'b1;
        hp;

        wq = {8'h11, 8'h22, 8'h33};
        do_write(4, 3, 3, "R3");
        do_read(4, 3, "R7");

        wq = {8'h5A};
        do_write(20, 1, 1, "R3 single");

        bstart;
        wbyte(8'hA0, a); check("R2 foreign address nack", a, 0);
        wbyte(8'h00, a); check("R2 no part after nack", a, 0);
        bstop;

        wq = {8'h99, 8'h98};
        do_write(5, 0, 2, "R4");

        wq = {8'hC1, 8'hC2, 8'hC3};
        do_write(24, 2, 3, "R5");

        wq = {8'hE0, 8'hE1, 8'hE2, 8'hE3};
        do_write(30, 4, 4, "R6");
        do_read(30, 4, "R6");

        wq = {8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
        do_write(3, 8, 8, "R9");
        check("R10 dummy byte 10 after write", int'(regs[87:80]), 0);
        check("R9 vendor byte after write", int'(regs[63:56]), 8'h15);
        do_read(3, 8, "R10");

        fs = 3'b101;
        hp;
        check("R9 status bits in byte3", int'(regs[31:24]), 8'hBF);
        do_read(3, 1, "R9");

        wq = {8'h03};
        do_write(8, 1, 1, "R7 count");
        do_read(0, 2, "R8 early end");
        do_read(0, 3, "R7");

        hp;
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
        $finish;
    end
endmodule